// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is a single 32-bit timer channel with a small word-addressed register interface. Software loads a reload value and a starting count, picks a clock division ratio, and then an external start control raises the channel enable. While the enable is high, the count steps down by one on every prescaled tick. A tick that finds the count at zero does not decrement. It loads the reload value and latches an underflow flag. The flag can be routed to the interrupt output through an enable bit. Software clears the flag by writing a zero to its position in the control register.

The control register also holds a clock-edge field and a capture-mode field. These are stored and read back, but they do nothing. The capture status bit always reads zero, and the capture register returns a constant. The channel supports a periodic mode through the reload path. It also supports one-shot style use, where software rewrites the count after each underflow.

Top module: `tmr_channel`

## Requirements
- R1: After a synchronous reset, the reload register and the count both read 0xFFFFFFFF, the control register reads 0, and `irq` is low.
- R2: Word registers sit at byte offsets 0x0 (reload), 0x4 (count), 0x8 (control) and 0xC (capture). The capture register always reads the parameter `CAPT_VALUE` (default 0). A write to 0xC changes nothing that can be read.
- R3: Control bits 2:0 select the tick period. Codes 0, 1, 2, 3 and 4 give one decrement every 4, 16, 64, 256 and 1024 clocks. Codes 5, 6 and 7 give one decrement every 4 clocks.
- R4: While `chan_en` is high, the count decrements once per tick. While `chan_en` is low, the count and the prescaler phase hold.
- R5: A tick that arrives while the count is zero loads the reload value into the count at that same edge and sets the underflow flag (control bit 8). Because ticks need `chan_en`, the flag can only be set while `chan_en` is high.
- R6: A control write with bit 8 equal to 0 clears the underflow flag. A control write with bit 8 equal to 1 leaves the flag as it was and never sets it.
- R7: `irq` is high exactly when the underflow flag and the interrupt enable (control bit 5) are both 1.
- R8: Control bits 7:0 read back as last written, and bits 4:3 and 7:6 have no effect on counting. Bit 9 and bits 31:10 always read 0.
- R9: A control write restarts the prescaler from zero, and no tick happens at the edge of that write. With `chan_en` held high, the next decrement comes a full period after the write.
- R10: A write to the count register loads the written value at the next edge. This write overrides a tick due at that edge, so no decrement and no underflow happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel run enable from the external start control |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte offset of the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Underflow interrupt, the flag gated by the interrupt enable |

## Verification
The embedded properties check these rules on every cycle:
- the prescaler restarts on a control write;
- ticks are never back to back;
- the count and the prescaler phase hold while idle;
- a count write wins over a tick;
- an underflow loads the reload value;
- a control write never sets the flag;
- the flag only rises while the channel was enabled.

The exact spacing of decrements for each division code needs the bench's scenarios, and so do the reset values, the read-back masking of reserved and capture bits, and the masking of the interrupt. These scenarios run alongside a long random mix of writes and enable toggles, which is compared each cycle against a reference model built from the requirements.

// File: rtl/tmr_pkg.sv
// Package: shared types, register word indices and the prescale decode
// for the reloading down-counter timer channel.
// Assumes: 4-byte word registers, and control bits 7:0 are the stored fields.
package tmr_pkg;

    localparam int PSC_W  = 3;   // width of the prescale select code
    localparam int PRE_W  = 10;  // enough bits for the largest period (1024)
    localparam int FLAG_BIT = 8; // underflow flag position in the control word

    // word index = byte offset / 4
    localparam logic [1:0] WORD_RELOAD = 2'd0;
    localparam logic [1:0] WORD_COUNT  = 2'd1;
    localparam logic [1:0] WORD_CTRL   = 2'd2;
    localparam logic [1:0] WORD_CAPT   = 2'd3;

    // stored control fields, bits 7:0 of the control word
    typedef struct packed {
        logic [1:0]       capt_mode; // bits 7:6, kept but inert
        logic             uf_ie;     // bit 5, underflow interrupt enable
        logic [1:0]       edge_sel;  // bits 4:3, kept but inert
        logic [PSC_W-1:0] psc;       // bits 2:0, prescale select
    } tmr_ctrl_t;

    // last prescaler phase (period - 1) for a select code; reserved codes act as /4
    function automatic logic [PRE_W-1:0] psc_last(input logic [PSC_W-1:0] code);
        logic [PRE_W-1:0] r;
        case (code)
            3'd0:    r = PRE_W'(3);
            3'd1:    r = PRE_W'(15);
            3'd2:    r = PRE_W'(63);
            3'd3:    r = PRE_W'(255);
            3'd4:    r = PRE_W'(1023);
            default: r = PRE_W'(3);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Divides the clock into single-cycle ticks, one every (last+1) clocks
// while run is high. A restart clears the phase and suppresses any tick
// in that cycle. Assumes last >= 3, so ticks are never adjacent.
module tmr_prescaler #(
    parameter int PRE_W = tmr_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] last,
    output logic             tick
);

    logic [PRE_W-1:0] phase;
    logic             at_end;

    // end of period reached (>= guards against a shorter ratio)
    assign at_end = (phase >= last);
    assign tick   = run && !restart && at_end;

    // advance, wrap or clear the phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (run) begin
            phase <= at_end ? '0 : phase + 1'b1;
        end
    end

    p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0 && !tick));

    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(phase));

endmodule

// File: rtl/tmr_downcount.sv
// Module: tmr_downcount
// Holds the live count. A software load wins over a tick. A tick on zero
// reloads the count and reports an underflow pulse in the same cycle.
// Assumes the tick input is already gated by the channel enable.
module tmr_downcount #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld_we,
    input  logic [W-1:0] ld_data,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         uf
);

    // underflow: a tick meets zero and no software load competes
    assign uf = tick && !ld_we && (count == '0);

    // count register: load, reload on underflow, or decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '1;
        end else if (ld_we) begin
            count <= ld_data;
        end else if (tick) begin
            count <= (count == '0) ? reload : count - 1'b1;
        end
    end

    p_reload_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> (count == $past(reload)));

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |=> (count == $past(ld_data)));

    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_we) |=> $stable(count));

endmodule

// File: rtl/tmr_regs.sv
// Module: tmr_regs
// Register file: decodes the word offset, keeps the reload value, the
// control fields and the underflow flag, and forms the read data.
// Assumes byte offsets, with bits 1:0 ignored, and W >= 16.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int           W          = 32,
    parameter logic [W-1:0] CAPT_VALUE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [3:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic         uf,
    input  logic [W-1:0] count,
    output logic [W-1:0] reload,
    output tmr_ctrl_t    ctrl,
    output logic         flag,
    output logic         cnt_we,
    output logic         ctrl_we,
    output logic [W-1:0] rdata,
    output logic         irq
);

    logic [1:0] word;
    logic       reload_we;
    logic       unused_addr;

    assign word        = bus_addr[3:2];
    assign unused_addr = ^bus_addr[1:0];
    assign reload_we   = bus_we && (word == WORD_RELOAD);
    assign cnt_we      = bus_we && (word == WORD_COUNT);
    assign ctrl_we     = bus_we && (word == WORD_CTRL);

    // reload value register
    always_ff @(posedge clk) begin
        if (!rst_n)         reload <= '1;
        else if (reload_we) reload <= bus_wdata;
    end

    // stored control fields; capture flag and reserved bits are dropped
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (ctrl_we) ctrl <= tmr_ctrl_t'(bus_wdata[7:0]);
    end

    // underflow flag: cleared by a zero written to its bit, set by underflow
    always_ff @(posedge clk) begin
        if (!rst_n)                                flag <= 1'b0;
        else if (ctrl_we && !bus_wdata[FLAG_BIT])  flag <= 1'b0;
        else if (uf)                               flag <= 1'b1;
    end

    // read multiplexer
    always_comb begin
        rdata = '0;
        case (word)
            WORD_RELOAD: rdata = reload;
            WORD_COUNT:  rdata = count;
            WORD_CTRL:   rdata[FLAG_BIT:0] = {flag, ctrl};
            default:     rdata = CAPT_VALUE;
        endcase
    end

    // interrupt request
    assign irq = flag && ctrl.uf_ie;

    p_write_never_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (flag == ($past(flag) && $past(bus_wdata[FLAG_BIT]))));

    p_ctrl_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (ctrl == $past(bus_wdata[7:0])));

endmodule

// File: rtl/tmr_channel.sv
// Module: tmr_channel (top)
// One reloading down-counter timer channel: register file, prescaler and
// count register. The channel enable gates the prescaler, and a control
// write restarts it. Assumes a single-cycle write strobe and combinational
// reads.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int           W          = 32,
    parameter logic [W-1:0] CAPT_VALUE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chan_en,
    input  logic         bus_we,
    input  logic [3:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq
);

    tmr_ctrl_t  ctrl;
    logic [W-1:0] reload;
    logic [W-1:0] count;
    logic         flag;
    logic         cnt_we;
    logic         ctrl_we;
    logic         tick;
    logic         uf;

    tmr_regs #(.W(W), .CAPT_VALUE(CAPT_VALUE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .uf        (uf),
        .count     (count),
        .reload    (reload),
        .ctrl      (ctrl),
        .flag      (flag),
        .cnt_we    (cnt_we),
        .ctrl_we   (ctrl_we),
        .rdata     (bus_rdata),
        .irq       (irq)
    );

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (chan_en),
        .restart (ctrl_we),
        .last    (psc_last(ctrl.psc)),
        .tick    (tick)
    );

    tmr_downcount #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ld_we   (cnt_we),
        .ld_data (bus_wdata),
        .reload  (reload),
        .count   (count),
        .uf      (uf)
    );

    p_flag_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(chan_en));

    p_no_tick_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> !tick);

endmodule

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
// Bench for tmr_channel: directed corner cases plus seeded random traffic.
// A reference model built from the requirements is compared with the
// read data and irq on every cycle.
module tb_tmr_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] last_rd;

    // reference model state
    logic [31:0] m_reload, m_count;
    logic [7:0]  m_ctrl;
    logic        m_flag;
    int          m_pc;

    always #2 clk = ~clk;

    tmr_channel dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int period(input logic [2:0] code);
        case (code)
            3'd0: return 4;
            3'd1: return 16;
            3'd2: return 64;
            3'd3: return 256;
            3'd4: return 1024;
            default: return 4;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a[3:2])
            2'd0: return m_reload;
            2'd1: return m_count;
            2'd2: return {23'd0, m_flag, m_ctrl};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one clock: drive at the falling edge, compare, then advance the model
    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] wd, input logic en);
        bit cw, nw, tk, uf;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; chan_en = en;
        #1;
        last_rd = bus_rdata;
        if (rst_n) begin
            case (a[3:2])
                2'd0, 2'd3: chk("R2 read", bus_rdata, exp_read(a));
                2'd1:       chk("R4 count", bus_rdata, exp_read(a));
                default:    chk("R8 control", bus_rdata, exp_read(a));
            endcase
            chk("R7 irq", {31'd0, irq}, {31'd0, m_flag & m_ctrl[5]});
        end
        cw = we && a[3:2] == 2'd2;
        nw = we && a[3:2] == 2'd1;
        tk = en && !cw && (m_pc >= period(m_ctrl[2:0]) - 1);
        uf = tk && !nw && (m_count == 0);
        @(posedge clk);
        if (!rst_n) begin
            m_reload = '1; m_count = '1; m_ctrl = '0; m_flag = 0; m_pc = 0;
        end else begin
            if (cw) m_pc = 0;
            else if (en) m_pc = (m_pc >= period(m_ctrl[2:0]) - 1) ? 0 : m_pc + 1;
            if (nw) m_count = wd;
            else if (tk) m_count = (m_count == 0) ? m_reload : m_count - 1;
            if (cw && !wd[8]) m_flag = 0;
            else if (uf) m_flag = 1;
            if (cw) m_ctrl = wd[7:0];
            if (we && a[3:2] == 2'd0) m_reload = wd;
        end
    endtask

    task automatic idle(input int n, input logic en);
        for (int i = 0; i < n; i++) step(0, 4'h4, 0, en);
    endtask

    task automatic rd(input logic [3:0] a);
        step(0, a, 0, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0;
        idle(3, 0);
        rst_n = 1;

        // R1: reset state
        rd(4'h0); chk("R1 reload", last_rd, 32'hFFFF_FFFF);
        rd(4'h4); chk("R1 count", last_rd, 32'hFFFF_FFFF);
        rd(4'h8); chk("R1 control", last_rd, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R3: decrement spacing for every select code (5..7 act as /4)
        for (int c = 0; c < 8; c++) begin
            step(1, 4'h8, c, 0);
            step(1, 4'h4, 32'd50, 0);
            idle(3 * period(3'(c)) - 1, 1);
            rd(4'h4); chk("R3 one period short", last_rd, 32'd48);
            step(0, 4'h4, 0, 1);
            rd(4'h4); chk("R3 three periods", last_rd, 32'd47);
        end

        // R4: disabled channel freezes
        idle(40, 0);
        rd(4'h4); chk("R4 frozen", last_rd, 32'd47);

        // R5 / R7: underflow reloads, sets flag, irq with enable
        step(1, 4'h0, 32'd7, 0);
        step(1, 4'h4, 32'd0, 0);
        step(1, 4'h8, 32'h20, 0);
        idle(4, 1);
        rd(4'h4); chk("R5 reload", last_rd, 32'd7);
        rd(4'h8); chk("R5 flag", last_rd, 32'h120);
        chk("R7 irq high", {31'd0, irq}, 32'd1);
        step(1, 4'h8, 32'h100, 0);
        rd(4'h8);
        chk("R7 irq masked", {31'd0, irq}, 32'd0);

        // R6: writing one keeps, writing zero clears, one never sets
        step(1, 4'h8, 32'h120, 0);
        rd(4'h8); chk("R6 kept", last_rd, 32'h120);
        step(1, 4'h8, 32'h020, 0);
        rd(4'h8); chk("R6 cleared", last_rd, 32'h020);
        step(1, 4'h8, 32'h120, 0);
        rd(4'h8); chk("R6 not set", last_rd, 32'h020);

        // R8: reserved and capture flag bits read zero
        step(1, 4'h8, 32'hFFFF_FEFF, 0);
        rd(4'h8); chk("R8 masking", last_rd, 32'h0FF);

        // R10: count write overrides a due tick
        step(1, 4'h8, 32'h0, 0);
        step(1, 4'h4, 32'd20, 0);
        idle(3, 1);
        step(1, 4'h4, 32'd99, 1);
        rd(4'h4); chk("R10 write wins", last_rd, 32'd99);
        rd(4'h8); chk("R10 no flag", last_rd, 32'h0);

        // R9: control write restarts the prescaler
        step(1, 4'h8, 32'h1, 0);
        step(1, 4'h4, 32'd10, 0);
        idle(10, 1);
        step(1, 4'h8, 32'h1, 1);
        idle(15, 1);
        rd(4'h4); chk("R9 no early tick", last_rd, 32'd10);
        step(0, 4'h4, 0, 1);
        rd(4'h4); chk("R9 full period", last_rd, 32'd9);

        // R2: capture register reads constant, writes ignored
        step(1, 4'hC, 32'h1234_5678, 0);
        rd(4'hC); chk("R2 capture", last_rd, 32'h0);
        rd(4'h0); chk("R2 reload intact", last_rd, 32'd7);
        rd(4'h4); chk("R2 count intact", last_rd, 32'd9);

        // random traffic against the model
        for (int i = 0; i < 20000; i++) begin
            logic [31:0] r, wd;
            logic [3:0]  a;
            r  = $urandom;
            a  = {r[5:4], 2'b00};
            wd = (a[3:2] == 2'd2) ? ($urandom & 32'h0000_FFF3) : ($urandom % 24);
            step(r[11:8] == 0, a, wd, r[14:12] != 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule